// File: doc/BRIEF.md
# Line Interface Loopback Path Controller

This block does the digital signal routing for one line-interface channel. Each signal is a sampled data word with a valid strobe, and all of them run in one system clock domain. Two mode bits choose where data moves between five places: the transmit input from the framer side, the transmit line output, the receive line input, the tap that feeds the receive processing chain (signal-loss detector, line decoder, pseudo-random pattern checker) and the receive output. The block exposes only these tap points. Line coding, the analog front end and the pattern checker are outside it.

The mode is held in a small state register with four states. `LB_OFF` keeps the two directions independent. `LB_REMOTE` sends recovered receive data back out on the transmit line and ignores the transmit input. `LB_ANALOG` returns the outgoing transmit line signal through a modelled front-end stage, which adds one cycle of delay. `LB_DIGITAL` feeds the transmit input straight into the receive chain. Both local modes ignore the receive line input and keep the transmit line output running. The bits select the next state directly every clock, so every state-to-state transition exists. The named transitions are ENTER_REMOTE, ENTER_ANALOG, ENTER_DIGITAL and RETURN_OFF, plus HOLD when the bits do not change. Every output comes from a flop, so a mode change cannot glitch a strobe.

Top module: `loopback_ctrl`

## Requirements
- R1: While reset is asserted, all data and strobe outputs are 0 and `mode_status` is 00.
- R2: `mode_status` equals {`loop_local`,`loop_remote`} sampled at the previous clock edge, with the encoding 00 off, 01 remote, 10 analog local, 11 digital local. The data paths follow the new mode from the edge after the one that loaded it.
- R3: In off mode, the transmit line output equals the transmit input one cycle later, and the chain tap equals the receive line input one cycle later.
- R4: In remote mode, the transmit line output equals the receive line input one cycle later, and the transmit input has no effect on it.
- R5: In remote mode, the receive line input still reaches the chain tap one cycle later and the receive output two cycles later.
- R6: In analog local mode, the chain tap equals the transmit line output from two cycles earlier. A transmit input word therefore reaches the chain tap three cycles later.
- R7: In digital local mode, the chain tap equals the transmit input one cycle later.
- R8: In both local modes, the transmit line output equals the transmit input one cycle later, and the receive line input has no effect on the chain tap.
- R9: In every mode, the receive output equals the chain tap one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous reset, active low |
| loop_local | input | 1 | local loopback request bit |
| loop_remote | input | 1 | remote loopback request bit |
| tx_dat | input | DW | transmit input data |
| tx_stb | input | 1 | transmit input valid strobe |
| line_rx_dat | input | DW | receive line input data |
| line_rx_stb | input | 1 | receive line input valid strobe |
| line_tx_dat | output | DW | transmit line output data |
| line_tx_stb | output | 1 | transmit line output valid strobe |
| chain_dat | output | DW | receive chain tap data |
| chain_stb | output | 1 | receive chain tap valid strobe |
| rx_dat | output | DW | receive output data |
| rx_stb | output | 1 | receive output valid strobe |
| mode_status | output | 2 | current mode, encoded as in R2 |

## Verification
The assertions assume that the mode bits and the data inputs are synchronous to `clk` and settle between edges. They also assume that reset is asserted before the first edge, so every pipeline register starts from zero and the two-cycle look-back in the analog check refers to defined values. The bench changes inputs only one time unit after a rising edge and asserts reset from time zero. It also waits for the mode register to settle before each latency measurement, so each single-cycle pulse travels through a pipeline that holds zeros.

// File: rtl/lb_pkg.sv
package lb_pkg;

    // Mode encoding is {local, remote}
    typedef enum logic [1:0] {
        LB_OFF     = 2'b00,
        LB_REMOTE  = 2'b01,
        LB_ANALOG  = 2'b10,
        LB_DIGITAL = 2'b11
    } lb_mode_t;

    // Source feeding the receive chain register
    typedef enum logic [1:0] {
        SRC_LINE   = 2'b00,
        SRC_FE_DLY = 2'b01,
        SRC_TX     = 2'b10
    } lb_src_t;

endpackage

// File: rtl/lb_mode_ctrl.sv
module lb_mode_ctrl
    import lb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     loop_local,
    input  logic     loop_remote,
    output lb_mode_t mode,
    output logic     tx_from_line,
    output lb_src_t  chain_src
);

    lb_mode_t state_q;
    lb_mode_t state_d;

    // Next state: bits pick the target directly
    always_comb begin
        unique case ({loop_local, loop_remote})
            2'b00:   state_d = LB_OFF;
            2'b01:   state_d = LB_REMOTE;
            2'b10:   state_d = LB_ANALOG;
            default: state_d = LB_DIGITAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LB_OFF;
        else        state_q <= state_d;
    end

    // Output decode from the registered state
    always_comb begin
        tx_from_line = 1'b0;
        chain_src    = SRC_LINE;
        unique case (state_q)
            LB_OFF:     chain_src = SRC_LINE;
            LB_REMOTE:  begin
                tx_from_line = 1'b1;
                chain_src    = SRC_LINE;
            end
            LB_ANALOG:  chain_src = SRC_FE_DLY;
            LB_DIGITAL: chain_src = SRC_TX;
            default:    chain_src = SRC_LINE;
        endcase
    end

    assign mode = state_q;

endmodule

// File: rtl/lb_tx_path.sv
module lb_tx_path #(
    parameter int DW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_from_line,
    input  logic [DW-1:0] tx_dat,
    input  logic          tx_stb,
    input  logic [DW-1:0] line_rx_dat,
    input  logic          line_rx_stb,
    output logic [DW-1:0] line_tx_dat,
    output logic          line_tx_stb
);

    localparam int SW = DW + 1;

    logic [SW-1:0] pick;
    logic [SW-1:0] out_q;

    always_comb begin
        if (tx_from_line) pick = {line_rx_dat, line_rx_stb};
        else              pick = {tx_dat, tx_stb};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= pick;
    end

    assign line_tx_dat = out_q[SW-1:1];
    assign line_tx_stb = out_q[0];

endmodule

// File: rtl/lb_rx_path.sv
module lb_rx_path
    import lb_pkg::*;
#(
    parameter int DW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  lb_src_t       chain_src,
    input  logic [DW-1:0] tx_dat,
    input  logic          tx_stb,
    input  logic [DW-1:0] line_rx_dat,
    input  logic          line_rx_stb,
    input  logic [DW-1:0] line_tx_dat,
    input  logic          line_tx_stb,
    output logic [DW-1:0] chain_dat,
    output logic          chain_stb,
    output logic [DW-1:0] rx_dat,
    output logic          rx_stb
);

    localparam int SW = DW + 1;

    logic [SW-1:0] fe_q;
    logic [SW-1:0] chain_d;
    logic [SW-1:0] chain_q;
    logic [SW-1:0] rx_q;

    // Modelled front end: one stage behind the transmit line output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fe_q <= '0;
        else        fe_q <= {line_tx_dat, line_tx_stb};
    end

    always_comb begin
        unique case (chain_src)
            SRC_FE_DLY: chain_d = fe_q;
            SRC_TX:     chain_d = {tx_dat, tx_stb};
            default:    chain_d = {line_rx_dat, line_rx_stb};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            rx_q    <= '0;
        end else begin
            chain_q <= chain_d;
            rx_q    <= chain_q;
        end
    end

    assign chain_dat = chain_q[SW-1:1];
    assign chain_stb = chain_q[0];
    assign rx_dat    = rx_q[SW-1:1];
    assign rx_stb    = rx_q[0];

endmodule

// File: rtl/loopback_ctrl.sv
module loopback_ctrl
    import lb_pkg::*;
#(
    parameter int DW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          loop_local,
    input  logic          loop_remote,
    input  logic [DW-1:0] tx_dat,
    input  logic          tx_stb,
    input  logic [DW-1:0] line_rx_dat,
    input  logic          line_rx_stb,
    output logic [DW-1:0] line_tx_dat,
    output logic          line_tx_stb,
    output logic [DW-1:0] chain_dat,
    output logic          chain_stb,
    output logic [DW-1:0] rx_dat,
    output logic          rx_stb,
    output logic [1:0]    mode_status
);

    lb_mode_t mode;
    logic     tx_from_line;
    lb_src_t  chain_src;

    lb_mode_ctrl u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .loop_local   (loop_local),
        .loop_remote  (loop_remote),
        .mode         (mode),
        .tx_from_line (tx_from_line),
        .chain_src    (chain_src)
    );

    lb_tx_path #(.DW(DW)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_from_line (tx_from_line),
        .tx_dat       (tx_dat),
        .tx_stb       (tx_stb),
        .line_rx_dat  (line_rx_dat),
        .line_rx_stb  (line_rx_stb),
        .line_tx_dat  (line_tx_dat),
        .line_tx_stb  (line_tx_stb)
    );

    lb_rx_path #(.DW(DW)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .chain_src    (chain_src),
        .tx_dat       (tx_dat),
        .tx_stb       (tx_stb),
        .line_rx_dat  (line_rx_dat),
        .line_rx_stb  (line_rx_stb),
        .line_tx_dat  (line_tx_dat),
        .line_tx_stb  (line_tx_stb),
        .chain_dat    (chain_dat),
        .chain_stb    (chain_stb),
        .rx_dat       (rx_dat),
        .rx_stb       (rx_stb)
    );

    assign mode_status = mode;

endmodule

// File: rtl/lb_checker.sv
module lb_checker #(
    parameter int DW = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          loop_local,
    input logic          loop_remote,
    input logic [DW-1:0] tx_dat,
    input logic          tx_stb,
    input logic [DW-1:0] line_rx_dat,
    input logic          line_rx_stb,
    input logic [DW-1:0] line_tx_dat,
    input logic          line_tx_stb,
    input logic [DW-1:0] chain_dat,
    input logic          chain_stb,
    input logic [DW-1:0] rx_dat,
    input logic          rx_stb,
    input logic [1:0]    mode_status
);

    a_r2_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> mode_status == $past({loop_local, loop_remote}));

    a_r3_off_tx: assert property (@(posedge clk) disable iff (!rst_n)
        mode_status == 2'b00 |=> {line_tx_dat, line_tx_stb} == $past({tx_dat, tx_stb}));

    a_r4_remote_tx: assert property (@(posedge clk) disable iff (!rst_n)
        mode_status == 2'b01 |=> {line_tx_dat, line_tx_stb} == $past({line_rx_dat, line_rx_stb}));

    a_r5_remote_chain: assert property (@(posedge clk) disable iff (!rst_n)
        mode_status == 2'b01 |=> {chain_dat, chain_stb} == $past({line_rx_dat, line_rx_stb}));

    a_r6_analog_chain: assert property (@(posedge clk) disable iff (!rst_n)
        mode_status == 2'b10 |=> {chain_dat, chain_stb} == $past({line_tx_dat, line_tx_stb}, 2));

    a_r7_digital_chain: assert property (@(posedge clk) disable iff (!rst_n)
        mode_status == 2'b11 |=> {chain_dat, chain_stb} == $past({tx_dat, tx_stb}));

    a_r8_local_tx: assert property (@(posedge clk) disable iff (!rst_n)
        mode_status[1] |=> {line_tx_dat, line_tx_stb} == $past({tx_dat, tx_stb}));

    a_r9_rx_follows_chain: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> {rx_dat, rx_stb} == $past({chain_dat, chain_stb}));

endmodule

bind loopback_ctrl lb_checker #(.DW(DW)) i_lb_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .loop_local  (loop_local),
    .loop_remote (loop_remote),
    .tx_dat      (tx_dat),
    .tx_stb      (tx_stb),
    .line_rx_dat (line_rx_dat),
    .line_rx_stb (line_rx_stb),
    .line_tx_dat (line_tx_dat),
    .line_tx_stb (line_tx_stb),
    .chain_dat   (chain_dat),
    .chain_stb   (chain_stb),
    .rx_dat      (rx_dat),
    .rx_stb      (rx_stb),
    .mode_status (mode_status)
);

// File: tb/test_loopback_ctrl.sv
module test_loopback_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic loop_local = 1'b0;
    logic loop_remote = 1'b0;
    logic [DW-1:0] tx_dat = '0;
    logic tx_stb = 1'b0;
    logic [DW-1:0] line_rx_dat = '0;
    logic line_rx_stb = 1'b0;
    logic [DW-1:0] line_tx_dat;
    logic line_tx_stb;
    logic [DW-1:0] chain_dat;
    logic chain_stb;
    logic [DW-1:0] rx_dat;
    logic rx_stb;
    logic [1:0] mode_status;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    loopback_ctrl #(.DW(DW)) i_loopback_ctrl (
        .clk(clk), .rst_n(rst_n),
        .loop_local(loop_local), .loop_remote(loop_remote),
        .tx_dat(tx_dat), .tx_stb(tx_stb),
        .line_rx_dat(line_rx_dat), .line_rx_stb(line_rx_stb),
        .line_tx_dat(line_tx_dat), .line_tx_stb(line_tx_stb),
        .chain_dat(chain_dat), .chain_stb(chain_stb),
        .rx_dat(rx_dat), .rx_stb(rx_stb),
        .mode_status(mode_status)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Step one rising edge, then settle away from it
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_mode(input logic l, input logic r);
        loop_local  = l;
        loop_remote = r;
    endtask

    task automatic set_tx(input logic d, input logic s);
        tx_dat = d;
        tx_stb = s;
    endtask

    task automatic set_line(input logic d, input logic s);
        line_rx_dat = d;
        line_rx_stb = s;
    endtask

    function automatic logic [7:0] ltx();
        return {6'd0, line_tx_dat, line_tx_stb};
    endfunction
    function automatic logic [7:0] chn();
        return {6'd0, chain_dat, chain_stb};
    endfunction
    function automatic logic [7:0] rxo();
        return {6'd0, rx_dat, rx_stb};
    endfunction

    task automatic test_reset();
        set_tx(1'b1, 1'b1);
        set_line(1'b1, 1'b1);
        set_mode(1'b1, 1'b1);
        tick();
        check("R1 line_tx", ltx(), 8'd0);
        check("R1 chain", chn(), 8'd0);
        check("R1 rx", rxo(), 8'd0);
        check("R1 mode", {6'd0, mode_status}, 8'd0);
        set_tx(1'b0, 1'b0);
        set_line(1'b0, 1'b0);
        set_mode(1'b0, 1'b0);
        rst_n = 1'b1;
        tick();
    endtask

    task automatic test_off();
        set_mode(1'b0, 1'b0);
        set_tx(1'b1, 1'b1);
        set_line(1'b0, 1'b1);
        tick();
        tick();
        check("R2 mode off", {6'd0, mode_status}, 8'd0);
        check("R3 off line_tx", ltx(), 8'd3);
        check("R3 off chain", chn(), 8'd1);
        tick();
        check("R9 off rx", rxo(), 8'd1);
        set_tx(1'b0, 1'b1);
        set_line(1'b1, 1'b0);
        tick();
        check("R3 off line_tx pattern2", ltx(), 8'd1);
        check("R3 off chain pattern2", chn(), 8'd2);
    endtask

    task automatic test_remote();
        set_mode(1'b0, 1'b1);
        tick();
        check("R2 mode remote", {6'd0, mode_status}, 8'd1);
        set_tx(1'b1, 1'b1);
        set_line(1'b0, 1'b1);
        tick();
        check("R4 remote line_tx ignores tx", ltx(), 8'd1);
        check("R5 remote chain", chn(), 8'd1);
        tick();
        check("R5 remote rx", rxo(), 8'd1);
        set_tx(1'b0, 1'b0);
        set_line(1'b1, 1'b1);
        tick();
        check("R4 remote line_tx follows line", ltx(), 8'd3);
        set_line(1'b1, 1'b0);
        tick();
        check("R4 remote line_tx pattern3", ltx(), 8'd2);
    endtask

    task automatic test_analog();
        set_mode(1'b1, 1'b0);
        set_tx(1'b0, 1'b0);
        set_line(1'b1, 1'b1);
        for (int i = 0; i < 4; i++) tick();
        check("R2 mode analog", {6'd0, mode_status}, 8'd2);
        check("R8 analog chain ignores line", chn(), 8'd0);
        set_tx(1'b1, 1'b1);
        tick();
        check("R8 analog line_tx", ltx(), 8'd3);
        check("R6 analog chain k", chn(), 8'd0);
        set_tx(1'b0, 1'b0);
        tick();
        check("R6 analog chain k+1", chn(), 8'd0);
        tick();
        check("R6 analog chain k+2", chn(), 8'd3);
        tick();
        check("R6 analog chain k+3", chn(), 8'd0);
        check("R9 analog rx", rxo(), 8'd3);
    endtask

    task automatic test_digital();
        set_mode(1'b1, 1'b1);
        set_tx(1'b0, 1'b0);
        set_line(1'b1, 1'b1);
        for (int i = 0; i < 3; i++) tick();
        check("R2 mode digital", {6'd0, mode_status}, 8'd3);
        check("R8 digital chain ignores line", chn(), 8'd0);
        set_tx(1'b1, 1'b1);
        tick();
        check("R7 digital chain", chn(), 8'd3);
        check("R8 digital line_tx", ltx(), 8'd3);
        set_tx(1'b0, 1'b0);
        tick();
        check("R7 digital chain after pulse", chn(), 8'd0);
        check("R9 digital rx", rxo(), 8'd3);
    endtask

    task automatic test_mode_switch();
        set_mode(1'b0, 1'b0);
        set_tx(1'b1, 1'b1);
        set_line(1'b0, 1'b1);
        tick();
        tick();
        set_mode(1'b0, 1'b1);
        tick();
        check("R2 switch mode loaded", {6'd0, mode_status}, 8'd1);
        check("R2 switch old path on load edge", ltx(), 8'd3);
        tick();
        check("R2 switch new path next edge", ltx(), 8'd1);
    endtask

    initial begin
        test_reset();
        test_off();
        test_remote();
        test_analog();
        test_digital();
        test_mode_switch();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule